// File: doc/BRIEF.md
# Oversampling Baud Rate Generator

The block derives serial-port bit timing from the system clock and a programmable 16-bit divisor. A two-bit mode selects one of three ratios. In the 16x and 8x oversampling modes, a sample tick fires every `divisor` clocks and a bit tick fires on every 16th or 8th sample tick. In direct mode the bit rate is the clock divided by the divisor, and the sample tick coincides with the bit tick. Both ticks are registered and aligned to the rising clock edge. They feed a transmitter and a receiver.

Software writes a new divisor and mode together through a one-cycle write strobe. While the generator runs, the write waits in a shadow stage and is applied at the next bit boundary, so a bit that is in progress is never cut short. While the generator is stopped (divisor 0), a write is applied on the following clock. A divisor of 0 halts both ticks.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, both tick outputs are low and the generator is stopped, as if divisor 0 were loaded.
- R2: Mode code 0 (16x) gives a sample tick every D clocks and a bit tick every 16*D clocks, where D is the divisor.
- R3: Mode code 1 (8x) gives a sample tick every D clocks and a bit tick every 8*D clocks.
- R4: Mode codes 2 and 3 (direct) give a bit tick every D clocks, and each bit tick coincides with a sample tick.
- R5: Every bit tick coincides with a sample tick. Exactly 16 (mode 0), 8 (mode 1) or 1 (direct) sample ticks fall in each bit period, the last of them on the bit tick.
- R6: With divisor 0 applied, both tick outputs stay low.
- R7: A write made while the generator is stopped applies on the next clock. If the write lands on edge W, the first sample tick is high after edge W+D+1 and the first bit tick after edge W+ratio*D+1.
- R8: A write made while the generator runs takes effect at the next bit boundary. That bit keeps the old period, and the counters restart from zero with the new setting.
- R9: A write whose edge coincides with a bit boundary misses that boundary and applies at the following one. Of several writes within one bit period, only the last is applied.
- R10: Divisor 65535 is supported. In direct mode it gives a bit period of 65535 clocks.
- R11: For divisors of 2 or more, each sample tick is high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for divisor and mode |
| cfg_div_i | input | 16 | Divisor; 0 stops the generator |
| cfg_mode_i | input | 2 | 0 = 16x, 1 = 8x, 2 or 3 = direct |
| sample_tick_o | output | 1 | Pulse at the oversampling rate |
| bit_tick_o | output | 1 | Pulse at the bit rate |

## Verification
Two events can fall on the same clock: a configuration write, and the bit boundary that would apply a pending setting. The bench counts the bit period exactly. It places a write strobe on the edge at which the bit tick rises, then expects one more full period at the old setting before the new one appears. A second case puts two writes inside one bit period and judges, from the later periods, that only the second write took effect.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    MODE_X16        = 2'd0,
    MODE_X8         = 2'd1,
    MODE_DIRECT     = 2'd2,
    MODE_DIRECT_ALT = 2'd3
  } baud_mode_e;

  localparam int OS_W = 4;

  // index of the last sample tick inside one bit
  function automatic logic [OS_W-1:0] os_last(baud_mode_e m);
    case (m)
      MODE_X16: return OS_W'(15);
      MODE_X8:  return OS_W'(7);
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/baud_cfg_stage.sv
module baud_cfg_stage
  import baud_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       mode_i,
  input  logic             boundary_i,
  output logic [DIV_W-1:0] act_div_o,
  output baud_mode_e       act_mode_o,
  output logic             load_o
);
  logic [DIV_W-1:0] pend_div_q;
  baud_mode_e       pend_mode_q;
  logic             pend_vld_q;
  logic             stopped;

  assign stopped = (act_div_o == '0);
  assign load_o  = pend_vld_q && (boundary_i || stopped);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_div_q  <= '0;
      pend_mode_q <= MODE_X16;
      pend_vld_q  <= 1'b0;
    end else if (we_i) begin
      pend_div_q  <= div_i;
      pend_mode_q <= baud_mode_e'(mode_i);
      pend_vld_q  <= 1'b1;
    end else if (load_o) begin
      pend_vld_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_div_o  <= '0;
      act_mode_o <= MODE_X16;
    end else if (load_o) begin
      act_div_o  <= pend_div_q;
      act_mode_o <= pend_mode_q;
    end
  end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             pulse_o
);
  logic [DIV_W-1:0] cnt_q;

  assign pulse_o = run_i && (cnt_q == div_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (restart_i || !run_i)    cnt_q <= '0;
    else if (pulse_o)                cnt_q <= '0;
    else                             cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/baud_os_counter.sv
module baud_os_counter
  import baud_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       step_i,
  input  baud_mode_e mode_i,
  output logic       bit_o
);
  logic [OS_W-1:0] cnt_q;
  logic [OS_W-1:0] last;

  assign last  = os_last(mode_i);
  assign bit_o = step_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (step_i)    cnt_q <= bit_o ? '0 : cnt_q + OS_W'(1);
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic [1:0]       cfg_mode_i,
  output logic             sample_tick_o,
  output logic             bit_tick_o
);
  localparam int N_TICK = 2;

  logic [DIV_W-1:0] act_div;
  baud_mode_e       act_mode;
  logic             load;
  logic             run;
  logic             s_pulse;
  logic             b_pulse;
  logic [N_TICK-1:0] tick_d;
  logic [N_TICK-1:0] tick_q;

  assign run = (act_div != '0);

  baud_cfg_stage #(.DIV_W(DIV_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .div_i      (cfg_div_i),
    .mode_i     (cfg_mode_i),
    .boundary_i (b_pulse),
    .act_div_o  (act_div),
    .act_mode_o (act_mode),
    .load_o     (load)
  );

  baud_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (load),
    .div_i     (act_div),
    .pulse_o   (s_pulse)
  );

  baud_os_counter u_os (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (load),
    .step_i    (s_pulse),
    .mode_i    (act_mode),
    .bit_o     (b_pulse)
  );

  assign tick_d = {b_pulse, s_pulse};

  for (genvar g = 0; g < N_TICK; g++) begin : g_tick_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tick_q[g] <= 1'b0;
      else         tick_q[g] <= tick_d[g];
    end
  end

  assign sample_tick_o = tick_q[0];
  assign bit_tick_o    = tick_q[1];
endmodule

// File: rtl/baud_tick_gen_checker.sv
module baud_tick_gen_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample_tick_o,
  input logic             bit_tick_o,
  input logic [DIV_W-1:0] act_div,
  input logic [1:0]       act_mode
);
  p_bit_on_sample_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> sample_tick_o);

  p_quiet_when_stopped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_div == '0 && $past(act_div) == '0) |-> (!sample_tick_o && !bit_tick_o));

  p_cfg_at_boundary_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(act_div) || !$stable(act_mode)) |-> (bit_tick_o || $past(act_div) == '0));

  p_sample_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_tick_o && act_div >= DIV_W'(2)) |=> !sample_tick_o);
endmodule

bind baud_tick_gen baud_tick_gen_checker #(.DIV_W(DIV_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sample_tick_o (sample_tick_o),
  .bit_tick_o    (bit_tick_o),
  .act_div       (act_div),
  .act_mode      (act_mode)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] div = '0;
  logic [1:0]  mode = '0;
  logic        sample;
  logic        bit_tk;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  logic        done = 1'b0;

  baud_tick_gen u_baud_tick_gen (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cfg_we_i      (we),
    .cfg_div_i     (div),
    .cfg_mode_i    (mode),
    .sample_tick_o (sample),
    .bit_tick_o    (bit_tk)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic int ratio(int m);
    return (m == 0) ? 16 : (m == 1) ? 8 : 1;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    we = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int d, input int m);
    div = 16'(d); mode = 2'(m); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_bit(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!bit_tk && n < 100000);
  endtask

  task automatic first_ticks(output int fs, output int fb);
    int n = 0;
    fs = 0; fb = 0;
    do begin
      @(negedge clk); n++;
      if (sample && fs == 0) fs = n;
      if (bit_tk) fb = n;
    end while (!bit_tk && n < 100000);
  endtask

  task automatic period(output int per, output int smp);
    per = 0; smp = 0;
    do begin
      @(negedge clk); per++;
      if (sample) smp++;
    end while (!bit_tk && per < 100000);
  endtask

  initial begin
    int fs, fb, per, smp, n, cnt;
    void'($urandom(32'd1234));
    @(negedge clk);
    chk(!sample && !bit_tk, "R1 reset outputs", int'(sample) + int'(bit_tk), 0);
    rst_n = 1'b1;
    cnt = 0;
    repeat (100) begin @(negedge clk); if (sample || bit_tk) cnt++; end
    chk(cnt == 0, "R6 stopped after reset", cnt, 0);

    // 16x, divisor 3
    wr(3, 0);
    first_ticks(fs, fb);
    chk(fs == 4, "R7 first sample", fs, 4);
    chk(fb == 49, "R7 first bit", fb, 49);
    period(per, smp);
    chk(per == 48, "R2 x16 bit period", per, 48);
    chk(smp == 16, "R5 x16 samples per bit", smp, 16);

    // 8x, divisor 5
    do_reset(); wr(5, 1);
    first_ticks(fs, fb);
    chk(fb == 41, "R3 first bit", fb, 41);
    period(per, smp);
    chk(per == 40, "R3 x8 bit period", per, 40);
    chk(smp == 8, "R5 x8 samples per bit", smp, 8);

    // direct modes
    do_reset(); wr(7, 2);
    first_ticks(fs, fb);
    chk(fs == 8 && fb == 8, "R4 direct first ticks", fb, 8);
    period(per, smp);
    chk(per == 7 && smp == 1, "R4 direct period", per, 7);
    do_reset(); wr(4, 3);
    first_ticks(fs, fb);
    period(per, smp);
    chk(per == 4 && smp == 1, "R4 mode 3 period", per, 4);

    // sample tick width
    do_reset(); wr(2, 0);
    do @(negedge clk); while (!sample);
    @(negedge clk);
    chk(!sample, "R11 sample one clock", int'(sample), 0);

    // change while running
    do_reset(); wr(4, 0);
    first_ticks(fs, fb);
    wr(3, 1);
    wait_bit(n);
    chk(n == 63, "R8 old bit completes", n, 63);
    period(per, smp);
    chk(per == 24 && smp == 8, "R8 new period", per, 24);

    // write on the boundary edge
    repeat (23) @(negedge clk);
    wr(5, 2);
    chk(bit_tk, "R9 write on boundary", int'(bit_tk), 1);
    period(per, smp);
    chk(per == 24, "R9 deferred one period", per, 24);
    period(per, smp);
    chk(per == 5, "R9 applied next boundary", per, 5);

    // last write wins
    wr(9, 2); wr(6, 0);
    wait_bit(n);
    chk(n == 3, "R9 boundary kept", n, 3);
    period(per, smp);
    chk(per == 96, "R9 last write wins", per, 96);

    // stop while running
    wr(0, 0);
    wait_bit(n);
    chk(n == 95, "R6 stop at boundary", n, 95);
    cnt = 0;
    repeat (300) begin @(negedge clk); if (sample || bit_tk) cnt++; end
    chk(cnt == 0, "R6 quiet after stop", cnt, 0);

    // random trials
    for (int t = 0; t < 8; t++) begin
      int d = 1 + int'($urandom % 12);
      int m = int'($urandom % 4);
      do_reset(); wr(d, m);
      first_ticks(fs, fb);
      chk(fs == d + 1, "R7 random first sample", fs, d + 1);
      chk(fb == ratio(m) * d + 1, "R7 random first bit", fb, ratio(m) * d + 1);
      period(per, smp);
      chk(per == ratio(m) * d, "R2 R3 R4 random period", per, ratio(m) * d);
      chk(smp == ratio(m), "R5 random samples", smp, ratio(m));
    end

    // largest divisor
    do_reset(); wr(65535, 2);
    first_ticks(fs, fb);
    chk(fb == 65536 && fs == 65536, "R10 max divisor", fb, 65536);
    @(negedge clk);
    chk(!bit_tk, "R10 max divisor pulse width", int'(bit_tk), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule